// File: doc/BRIEF.md
# Burst Read Data and WAIT Sequencer

This block sits at the output of a synchronous parallel memory with a 16-bit data bus. A read request loads a latency count. Once that count runs out, the block places a fixed number of burst words on the data pins. Each word stays on the pins for one data cycle. The data cycle is one clock or two clocks, depending on a configuration bit. While the memory is not yet ready, the block drives an active-high WAIT flag with its own enable. A second configuration bit decides when WAIT clears. It either clears one full data cycle ahead of the first valid word, or it clears in the same clock as that word.

Words come from an upstream source that presents its current word combinationally. The block pulses a fetch strobe in the last clock before each word is needed. A read can also be marked asynchronous. An asynchronous read returns a single word, and its WAIT always clears together with the data. While a write is in progress, the WAIT enable is held low, any read is stopped and read requests are ignored. Whether the one-clock data cycle meets the host's setup timing is left to the configuration and is not checked.

Top module: `burst_wait_seq`

## Requirements
- R1: After reset the outputs are idle (`dq_valid_o`=0, `dq_o`=0, `wait_oe_o`=0, `src_rd_o`=0). Both configuration bits reset to 1, so the default is a two-clock data cycle with early WAIT release.
- R2: The data-cycle length is set by the hold bit: 1 gives two clocks per word and 0 gives one clock. `dq_valid_o` is high for exactly N data cycles back to back. N is `BURST_WORDS` for a synchronous read and 1 for an asynchronous read.
- R3: A start with latency L makes `dq_valid_o` rise max(L,1) clocks after the clock edge that samples the start.
- R4: With the delay bit at 1 on a synchronous read, WAIT is high during the latency clocks except the last D of them, where D is the data-cycle length. WAIT is low during data.
- R5: With the delay bit at 0, WAIT is high during every latency clock and falls in the clock where the first word becomes valid.
- R6: `wait_oe_o` is high only while a read is in its latency or data phase and no write is in progress. `wait_o` is 0 whenever `wait_oe_o` is 0.
- R7: `src_rd_o` pulses once for each word, in the clock just before that word's data cycle. The word shown is the `src_data_i` value present during that pulse. Within a data cycle, `dq_o` does not change.
- R8: An asynchronous read (`async_i`=1 at start) returns one word, and its WAIT ignores the delay bit, behaving as in R5.
- R9: `wr_busy_i`=1 forces `wait_oe_o` low in the same clock, ends any read at the next edge, and blocks a start sampled in the same clock.
- R10: A start during a read in progress drops that read and begins the new one with its own latency.
- R11: A configuration write (`cfg_wr_i`) takes effect from the next start onward. A read already running, or one started in the same clock as the write, uses the previous values.
- R12: `dq_o` is 0 in every clock where `dq_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a read (also restarts one in progress) |
| async_i | input | 1 | Sampled with start: 1 = asynchronous single-word read |
| lat_i | input | LAT_W | Latency in clocks, sampled with start (0 treated as 1) |
| wr_busy_i | input | 1 | A write is in progress |
| cfg_wr_i | input | 1 | Load the configuration bits |
| cfg_hold_i | input | 1 | Hold bit: 1 = two-clock data cycle, 0 = one clock |
| cfg_wdly_i | input | 1 | Delay bit: 1 = WAIT clears one data cycle early, 0 = with data |
| src_data_i | input | DW | Current word from the source |
| src_rd_o | output | 1 | Fetch strobe; the source advances at the edge that ends it |
| dq_o | output | DW | Data bus |
| dq_valid_o | output | 1 | Data bus carries a valid burst word |
| wait_o | output | 1 | WAIT flag, active high |
| wait_oe_o | output | 1 | WAIT output enable |

## Verification
Some properties are checked on every clock by the bound checker:
- WAIT is never driven while its enable is low.
- A write always disables WAIT.
- The bus is zero outside data.
- Data never changes inside a data cycle.
- Valid data never rises without a fetch in the clock before it.

The exact clock where WAIT falls relative to the first word, the number of words, the latency offset, aborts and the deferred effect of configuration writes depend on the whole burst history. Those are shown only by the bench's scenarios, which compare every clock of each burst with a timeline computed from L, D and N.

// File: rtl/bsq_pkg.sv
package bsq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LAT  = 2'd1,
    ST_DATA = 2'd2
  } bsq_st_e;
endpackage

// File: rtl/bsq_lat_cnt.sv
// Latency down-counter: loaded on a start, counts while in the latency phase.
module bsq_lat_cnt #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LAT_W-1:0] load_val,
  input  logic             run,
  output logic [LAT_W-1:0] cnt_o,
  output logic             last_o
);
  logic [LAT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = (load_val == '0) ? LAT_W'(1) : load_val;
    end else if (run && (cnt_q > LAT_W'(1))) begin
      cnt_d = cnt_q - LAT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = (cnt_q <= LAT_W'(1));
endmodule

// File: rtl/bsq_beat.sv
// Data-cycle timer: clock position inside a data cycle and words remaining.
module bsq_beat #(
  parameter int BURST_WORDS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic single,
  input  logic two_clk,
  input  logic run,
  output logic cyc_end_o,
  output logic last_word_o
);
  localparam int WCW = (BURST_WORDS > 1) ? $clog2(BURST_WORDS) : 1;

  logic           sub_q, sub_d;
  logic [WCW-1:0] left_q, left_d;

  assign cyc_end_o   = two_clk ? sub_q : 1'b1;
  assign last_word_o = (left_q == '0);

  always_comb begin
    sub_d  = sub_q;
    left_d = left_q;
    if (clr) begin
      sub_d  = 1'b0;
      left_d = single ? '0 : WCW'(BURST_WORDS - 1);
    end else if (run) begin
      if (cyc_end_o) begin
        sub_d = 1'b0;
        if (left_q != '0) left_d = left_q - WCW'(1);
      end else begin
        sub_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub_q  <= 1'b0;
      left_q <= '0;
    end else begin
      sub_q  <= sub_d;
      left_q <= left_d;
    end
  end
endmodule

// File: rtl/burst_wait_seq.sv
module burst_wait_seq
  import bsq_pkg::*;
#(
  parameter int DW          = 16,
  parameter int LAT_W       = 4,
  parameter int BURST_WORDS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             async_i,
  input  logic [LAT_W-1:0] lat_i,
  input  logic             wr_busy_i,
  input  logic             cfg_wr_i,
  input  logic             cfg_hold_i,
  input  logic             cfg_wdly_i,
  input  logic [DW-1:0]    src_data_i,
  output logic             src_rd_o,
  output logic [DW-1:0]    dq_o,
  output logic             dq_valid_o,
  output logic             wait_o,
  output logic             wait_oe_o
);
  bsq_st_e          st_q, st_d;
  logic             cfg_hold_q, cfg_wdly_q;
  logic             act_hold_q, act_wdly_q, act_async_q;
  logic [DW-1:0]    dreg_q;
  logic [LAT_W-1:0] lat_cnt;
  logic             lat_last, cyc_end, last_word;
  logic             go, lat_done, more, fetch, early;
  logic [1:0]       data_clks;

  assign go       = start_i & ~wr_busy_i;
  assign lat_done = (st_q == ST_LAT) & lat_last;
  assign more     = (st_q == ST_DATA) & cyc_end & ~last_word;
  assign fetch    = ~wr_busy_i & ~start_i & (lat_done | more);

  bsq_lat_cnt #(.LAT_W(LAT_W)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (go),
    .load_val (lat_i),
    .run      (st_q == ST_LAT),
    .cnt_o    (lat_cnt),
    .last_o   (lat_last)
  );

  bsq_beat #(.BURST_WORDS(BURST_WORDS)) u_beat (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (lat_done),
    .single      (act_async_q),
    .two_clk     (act_hold_q),
    .run         (st_q == ST_DATA),
    .cyc_end_o   (cyc_end),
    .last_word_o (last_word)
  );

  // next state
  always_comb begin
    st_d = st_q;
    if (wr_busy_i) begin
      st_d = ST_IDLE;
    end else if (start_i) begin
      st_d = ST_LAT;
    end else begin
      unique case (st_q)
        ST_LAT:  if (lat_done) st_d = ST_DATA;
        ST_DATA: if (cyc_end && last_word) st_d = ST_IDLE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  // configuration bits, enabled by a write
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_hold_q <= 1'b1;
      cfg_wdly_q <= 1'b1;
    end else if (cfg_wr_i) begin
      cfg_hold_q <= cfg_hold_i;
      cfg_wdly_q <= cfg_wdly_i;
    end
  end

  // per-read snapshot, enabled by an accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_hold_q  <= 1'b1;
      act_wdly_q  <= 1'b1;
      act_async_q <= 1'b0;
    end else if (go) begin
      act_hold_q  <= cfg_hold_q;
      act_wdly_q  <= cfg_wdly_q;
      act_async_q <= async_i;
    end
  end

  // output word register, enabled by the fetch strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dreg_q <= '0;
    else if (fetch) dreg_q <= src_data_i;
  end

  assign data_clks  = act_hold_q ? 2'd2 : 2'd1;
  assign early      = act_wdly_q & ~act_async_q;
  assign src_rd_o   = fetch;
  assign dq_valid_o = (st_q == ST_DATA);
  assign dq_o       = dq_valid_o ? dreg_q : '0;
  assign wait_oe_o  = (st_q != ST_IDLE) & ~wr_busy_i;
  assign wait_o     = wait_oe_o & (st_q == ST_LAT) &
                      (~early | (lat_cnt > LAT_W'(data_clks)));
endmodule

// File: rtl/bsq_chk.sv
module bsq_chk #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_busy_i,
  input logic          src_rd_o,
  input logic [DW-1:0] dq_o,
  input logic          dq_valid_o,
  input logic          wait_o,
  input logic          wait_oe_o
);
  // R6
  wait_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_oe_o |-> !wait_o);
  // R9
  wr_disables_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_busy_i |-> !wait_oe_o);
  // R12
  bus_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_valid_o |-> (dq_o == '0));
  // R7
  word_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_valid_o && $past(dq_valid_o) && !$past(src_rd_o)) |-> $stable(dq_o));
  // R7
  fetch_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_valid_o) |-> $past(src_rd_o));
  // R4
  no_wait_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_valid_o |-> !wait_o);
endmodule

bind burst_wait_seq bsq_chk #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_busy_i  (wr_busy_i),
  .src_rd_o   (src_rd_o),
  .dq_o       (dq_o),
  .dq_valid_o (dq_valid_o),
  .wait_o     (wait_o),
  .wait_oe_o  (wait_oe_o)
);

// File: tb/sim_burst_wait_seq.sv
module sim_burst_wait_seq;
  localparam int CLK_P = 10;
  localparam int BW    = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, async_rd, wr_busy, cfg_wr, cfg_hold, cfg_wdly;
  logic [3:0]  lat;
  logic [15:0] src_data, dq;
  logic        src_rd, dq_valid, wait_f, wait_oe;
  logic [15:0] ctr;
  int          total = 0;
  int          bad   = 0;
  bit          done  = 1'b0;
  bit          m_hold, m_wd;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [15:0] word_of(input logic [15:0] x);
    return (x * 16'h9E37) ^ 16'h5A5A;
  endfunction

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      ctr <= '0;
    else if (src_rd) ctr <= ctr + 16'd1;
  assign src_data = word_of(ctr);

  burst_wait_seq #(.DW(16), .LAT_W(4), .BURST_WORDS(BW)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .async_i(async_rd), .lat_i(lat),
    .wr_busy_i(wr_busy), .cfg_wr_i(cfg_wr), .cfg_hold_i(cfg_hold), .cfg_wdly_i(cfg_wdly),
    .src_data_i(src_data), .src_rd_o(src_rd), .dq_o(dq), .dq_valid_o(dq_valid),
    .wait_o(wait_f), .wait_oe_o(wait_oe)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic write_cfg(input bit h, input bit w);
    cfg_wr = 1'b1; cfg_hold = h; cfg_wdly = w;
    @(posedge clk); @(negedge clk);
    cfg_wr = 1'b0;
    m_hold = h; m_wd = w;
  endtask

  // Drives a start at the current negedge and checks every clock up to one idle clock.
  task automatic run_burst(input int L, input bit asy, input bit flip_cfg);
    int ld, d, n, tot, widx;
    logic [15:0] base;
    bit e_wait, e_valid;
    ld = (L == 0) ? 1 : L;
    d  = m_hold ? 2 : 1;
    n  = asy ? 1 : BW;
    tot = ld + n * d;
    base = ctr;
    start = 1'b1; async_rd = asy; lat = 4'(L);
    @(posedge clk); @(negedge clk);
    start = 1'b0;
    for (int k = 1; k <= tot + 1; k++) begin
      e_valid = (k > ld) && (k <= tot);
      if (k <= ld) e_wait = (asy || !m_wd) ? 1'b1 : ((ld - k + 1) > d);
      else         e_wait = 1'b0;
      widx = e_valid ? (k - ld - 1) / d : 0;
      check("R2/R3", "valid", 32'(dq_valid), 32'(e_valid));
      check(e_valid ? "R7" : "R12", "dq", 32'(dq),
            e_valid ? 32'(word_of(base + 16'(widx))) : 32'd0);
      check(asy ? "R8" : (m_wd ? "R4" : "R5"), "wait", 32'(wait_f), 32'(e_wait));
      check("R6", "wait_oe", 32'(wait_oe), 32'(k <= tot));
      if (flip_cfg && k == 1) begin
        cfg_wr = 1'b1; cfg_hold = !m_hold; cfg_wdly = !m_wd;
      end else begin
        cfg_wr = 1'b0;
      end
      @(negedge clk);
    end
    check("R7", "fetch count", 32'(ctr - base), 32'(n + 1 - 1) + 32'(1) - 32'(1));
    if (flip_cfg) begin m_hold = !m_hold; m_wd = !m_wd; end   // R11 applies from next start
    // one more idle clock was consumed above; bench is at a negedge
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] snap;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 0; async_rd = 0; lat = 0; wr_busy = 0;
    cfg_wr = 0; cfg_hold = 0; cfg_wdly = 0;
    m_hold = 1'b1; m_wd = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "valid", 32'(dq_valid), 0);
    check("R1", "dq", 32'(dq), 0);
    check("R1", "wait_oe", 32'(wait_oe), 0);
    check("R1", "src_rd", 32'(src_rd), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "idle after release", 32'(wait_oe), 0);

    // R1 defaults: two-clock cycle, early WAIT
    run_burst(6, 0, 0);
    // R3 latency zero treated as one
    run_burst(0, 0, 0);
    // R5 with one-clock cycle
    write_cfg(0, 0);
    run_burst(5, 0, 0);
    // R4 with one-clock cycle
    write_cfg(0, 1);
    run_burst(4, 0, 0);
    // R8 async ignores early release
    write_cfg(1, 1);
    run_burst(7, 1, 0);
    // R11 write during a read does not affect it
    run_burst(5, 0, 1);
    run_burst(5, 0, 0);

    // R11 start in same clock as a write uses old values
    m_hold = 1'b0; m_wd = 1'b0;
    write_cfg(1, 1);
    cfg_wr = 1'b1; cfg_hold = 1'b0; cfg_wdly = 1'b0;
    run_burst(3, 0, 0);
    m_hold = 1'b0; m_wd = 1'b0;
    run_burst(3, 0, 0);

    // R10 abort during latency
    write_cfg(1, 1);
    start = 1; lat = 4'd9; async_rd = 0;
    @(posedge clk); @(negedge clk); start = 0;
    repeat (3) @(negedge clk);
    run_burst(2, 0, 0);
    // R10 abort during data
    start = 1; lat = 4'd1;
    @(posedge clk); @(negedge clk); start = 0;
    repeat (2) @(negedge clk);
    check("R10", "in data before abort", 32'(dq_valid), 1);
    run_burst(3, 0, 0);

    // R9 write stops a read and blocks start
    start = 1; lat = 4'd6;
    @(posedge clk); @(negedge clk); start = 0;
    @(negedge clk);
    snap = ctr;
    wr_busy = 1'b1; start = 1'b1;
    #1;
    check("R9", "oe same clock", 32'(wait_oe), 0);
    check("R9", "wait same clock", 32'(wait_f), 0);
    @(posedge clk); @(negedge clk);
    wr_busy = 1'b0; start = 1'b0;
    check("R9", "valid during write", 32'(dq_valid), 0);
    @(posedge clk); @(negedge clk);
    check("R9", "oe after write", 32'(wait_oe), 0);
    check("R9", "no fetch", 32'(ctr - snap), 0);

    // random mix
    for (int i = 0; i < 40; i++) begin
      if (($urandom % 3) == 0) write_cfg(1'($urandom), 1'($urandom));
      run_burst(int'($urandom % 16), (($urandom % 4) == 0), (($urandom % 5) == 0));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule